// File: doc/BRIEF.md
# Quad-SPI Serial Clock Engine

This block generates the serial clock for a quad-SPI master. It runs entirely in the peripheral clock domain. One 32-bit configuration word, at offset 0x20 of a small register bus, holds four settings: the clock idle level, the phase mode, a baud divider and a lead-in delay. A write-protect input can freeze that word. Reads are always allowed.

A transfer begins with a start strobe and a bit count. The block asserts chip select and waits for the programmed lead-in delay. It then toggles the serial clock for exactly the requested number of periods and ends with the clock back at its idle level. For each bit it produces one single-cycle launch strobe and one single-cycle capture strobe, so that a separate shifter knows when to drive data and when to sample it. The timing settings are latched when the transfer starts.

Top module: `qspi_sclk_gen`

## Requirements
- R1: The configuration word at offset 0x20 resets to zero. Its layout is: bit 0 idle level (`cpol`), bit 1 phase mode (`cpha`), bits 15:8 baud divider, bits 23:16 lead-in delay. All other bits read as zero, and other offsets read as zero.
- R2: While `wp_en` is 1, a bus write to the configuration word leaves it unchanged. Reads still return its contents.
- R3: While no transfer is running, `sclk` sits at the level `cpol` selects: 0 means low, 1 means high. It is at that level again in the cycle `busy` falls.
- R4: A serial clock period P is max(divider,1)+1 peripheral cycles. P cycles separate consecutive leading edges, and each leading edge is followed by the trailing edge floor(P/2) cycles later.
- R5: The first `sclk` transition comes D cycles after the cycle in which `cs_n` goes low. D is the delay field when that field is nonzero, and floor(P/2) when it is zero.
- R6: A start with a nonzero count while idle drives `cs_n` low and `busy` high on the next cycle. It then produces exactly 2×count transitions of `sclk`. `busy` falls and `cs_n` rises together with the final trailing edge.
- R7: With `cpha`=0, `capture` pulses with each leading edge. `launch` pulses once when chip select asserts and with every trailing edge except the last. With `cpha`=1, `launch` pulses with each leading edge and `capture` with each trailing edge. Each strobe lasts one cycle, the two never pulse together, and neither pulses while the block is idle.
- R8: Divider, delay, `cpol` and `cpha` are taken at start. A configuration write during a transfer changes the stored word but not the transfer in progress.
- R9: A start strobe while busy is ignored, and so is a start with a bit count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| wp_en | input | 1 | Write-protect enable |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_bits | input | BITS_W | Number of serial clock periods |
| busy | output | 1 | Transfer in progress |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| launch | output | 1 | Drive-next-bit strobe |
| capture | output | 1 | Sample-bit strobe |

## Verification
The hardest case to reach from the ports is a change to the configuration word in the middle of a transfer, combined with a second start strobe. Either one could disturb a transfer that is already running. The random loop does both. In chosen transfers it writes a fresh random configuration one cycle after start, and in others it pulses start again with a different count two cycles in. The bench then checks the first-edge delay, period, duty split and edge count against the values latched at start, and reads back the new word once the transfer has finished. Directed runs cover the extremes of the divider and the delay, including a zero divider, the largest divider, and a zero delay with an odd period.

// File: rtl/qspi_sclk_gen.sv
module qspi_sclk_gen #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h20,
  parameter int BITS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wp_en,
  input  logic              xfer_start,
  input  logic [BITS_W-1:0] xfer_bits,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic              launch,
  output logic              capture
);
  localparam int FW = 8;
  localparam int DIV_LSB = 8;
  localparam int DLY_LSB = 16;

  typedef enum logic [1:0] {S_IDLE, S_DELAY, S_RUN} state_t;

  state_t          state;
  logic            cpol_q, cpha_q, s_cpol, s_cpha;
  logic [FW-1:0]   div_q, dly_q, s_h1, s_h2, cnt;
  logic [BITS_W-1:0] bits_left;
  logic            lead_half, sclk_q, cs_n_q, launch_q, capture_q;

  logic            cfg_hit, wr_ok, begin_x;
  logic [FW-1:0]   div_eff, h1, h2, delay;
  logic [FW:0]     per_len, h2_w;

  assign cfg_hit   = reg_addr == CFG_OFFSET;
  assign wr_ok     = reg_wr && cfg_hit && !wp_en;
  assign reg_rdata = cfg_hit ? {{(DATA_W-24){1'b0}}, dly_q, div_q, 6'b0, cpha_q, cpol_q} : '0;

  assign div_eff = (div_q == '0) ? FW'(1) : div_q;
  assign per_len = {1'b0, div_eff} + 1'b1;
  assign h1      = per_len[FW:1];
  assign h2_w    = per_len - {1'b0, h1};
  assign h2      = h2_w[FW-1:0];
  assign delay   = (dly_q != '0) ? dly_q : h1;

  assign busy    = state != S_IDLE;
  assign begin_x = xfer_start && !busy && (xfer_bits != '0);
  assign sclk    = sclk_q;
  assign cs_n    = cs_n_q;
  assign launch  = launch_q;
  assign capture = capture_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      div_q     <= '0;
      dly_q     <= '0;
      s_cpol    <= 1'b0;
      s_cpha    <= 1'b0;
      s_h1      <= '0;
      s_h2      <= '0;
      cnt       <= '0;
      bits_left <= '0;
      lead_half <= 1'b0;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        cpol_q <= reg_wdata[0];
        cpha_q <= reg_wdata[1];
        div_q  <= reg_wdata[DIV_LSB +: FW];
        dly_q  <= reg_wdata[DLY_LSB +: FW];
      end
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
      case (state)
        S_IDLE: begin
          sclk_q <= cpol_q;
          cs_n_q <= 1'b1;
          if (begin_x) begin
            state     <= S_DELAY;
            cs_n_q    <= 1'b0;
            cnt       <= delay - 1'b1;
            bits_left <= xfer_bits;
            s_cpol    <= cpol_q;
            s_cpha    <= cpha_q;
            s_h1      <= h1;
            s_h2      <= h2;
            launch_q  <= !cpha_q;
          end
        end
        S_DELAY: begin
          if (cnt == '0) begin
            state     <= S_RUN;
            sclk_q    <= ~sclk_q;
            lead_half <= 1'b1;
            cnt       <= s_h1 - 1'b1;
            launch_q  <= s_cpha;
            capture_q <= !s_cpha;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RUN: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (lead_half) begin
            sclk_q    <= ~sclk_q;
            lead_half <= 1'b0;
            cnt       <= s_h2 - 1'b1;
            bits_left <= bits_left - 1'b1;
            capture_q <= s_cpha;
            launch_q  <= !s_cpha && (bits_left != BITS_W'(1));
            if (bits_left == BITS_W'(1)) begin
              state  <= S_IDLE;
              cs_n_q <= 1'b1;
            end
          end else begin
            sclk_q    <= ~sclk_q;
            lead_half <= 1'b1;
            cnt       <= s_h1 - 1'b1;
            launch_q  <= s_cpha;
            capture_q <= !s_cpha;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_wp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wp_en) |=> $stable({cpol_q, cpha_q, div_q, dly_q}));

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && capture));

  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> (!launch && !capture));

  a_r7_capture_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (sclk != $past(sclk)));

  a_r3_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sclk == s_cpol));

  a_r6_cs_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $fell(cs_n));
endmodule

// File: tb/qspi_sclk_gen_tb.sv
module qspi_sclk_gen_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BITS_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic wp_en = 1'b0;
  logic xfer_start = 1'b0;
  logic [BITS_W-1:0] xfer_bits = '0;
  logic busy, cs_n, sclk, launch, capture;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qspi_sclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wp_en(wp_en),
    .xfer_start(xfer_start), .xfer_bits(xfer_bits), .busy(busy),
    .cs_n(cs_n), .sclk(sclk), .launch(launch), .capture(capture)
  );

  function automatic int period_of(input int dv);
    return ((dv == 0) ? 1 : dv) + 1;
  endfunction

  function automatic int delay_of(input int dv, input int dl);
    return (dl != 0) ? dl : period_of(dv) / 2;
  endfunction

  function automatic logic [31:0] cfg_word(input bit pol, input bit pha, input int dv, input int dl);
    return {8'h00, dl[7:0], dv[7:0], 6'b0, pha, pol};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_xfer(input bit pol, input bit pha, input int dv, input int dl, input int n,
                          input bit midwrite, input bit restart);
    logic [31:0] rd, neww;
    int p, h1, d, t, edges, first, lastlead, lastedge, per_err, h1_err, st_err, nl, nc;
    bit prev, lead, el, ec;
    p = period_of(dv); h1 = p / 2; d = delay_of(dv, dl);
    neww = cfg_word(~pol, $urandom_range(0, 1), $urandom_range(0, 255), $urandom_range(0, 255));
    bus_write(8'h20, cfg_word(pol, pha, dv, dl));
    repeat (2) @(negedge clk);
    chk(sclk == pol, "R3 idle sclk level", sclk, pol);
    bus_read(8'h20, rd);
    chk(rd == cfg_word(pol, pha, dv, dl), "R1 readback", rd, cfg_word(pol, pha, dv, dl));
    @(negedge clk);
    xfer_start = 1'b1; xfer_bits = BITS_W'(n);
    @(negedge clk);
    xfer_start = 1'b0;
    t = 0;
    chk(!cs_n && busy, "R6 cs_n low and busy after start", {cs_n, busy}, 1);
    edges = 0; first = -1; lastlead = -1; lastedge = -1;
    per_err = 0; h1_err = 0; st_err = 0;
    nl = launch; nc = capture;
    if (launch != !pha || capture) st_err++;
    prev = sclk;
    while (busy && t < 100000) begin
      if (t == 1 && midwrite) begin reg_addr = 8'h20; reg_wdata = neww; reg_wr = 1'b1; end
      else reg_wr = 1'b0;
      if (t == 2 && restart) begin xfer_start = 1'b1; xfer_bits = BITS_W'(n + 3); end
      else xfer_start = 1'b0;
      @(negedge clk);
      t++;
      nl += launch; nc += capture;
      if (sclk != prev) begin
        edges++;
        lastedge = t;
        lead = edges[0];
        if (edges == 1) first = t;
        if (lead) begin
          if (lastlead >= 0 && t - lastlead != p) per_err++;
          lastlead = t;
        end else if (t - lastlead != h1) h1_err++;
        ec = pha ? !lead : lead;
        el = pha ? lead : (!lead && edges != 2 * n);
        if (capture != ec || launch != el) st_err++;
      end else if (launch || capture) st_err++;
      prev = sclk;
    end
    reg_wr = 1'b0; xfer_start = 1'b0;
    chk(first == d, midwrite ? "R5 R8 first edge delay" : "R5 first edge delay", first, d);
    chk(per_err == 0, midwrite ? "R4 R8 period errors" : "R4 period errors", per_err, 0);
    chk(h1_err == 0, "R4 leading-to-trailing errors", h1_err, 0);
    chk(edges == 2 * n, restart ? "R6 R9 transition count" : "R6 transition count", edges, 2 * n);
    chk(lastedge == t && cs_n, "R6 busy and cs_n end at last edge", t, lastedge);
    chk(sclk == pol, "R3 sclk level when busy falls", sclk, pol);
    chk(st_err == 0 && nl == n && nc == n, "R7 strobe placement",
        st_err * 1000 + nl * 100 + nc, n * 100 + n);
    if (midwrite) begin
      bus_read(8'h20, rd);
      chk(rd == neww, "R8 mid-transfer write stored", rd, neww);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(8'h20, rd);
    chk(rd == 0, "R1 reset value", rd, 0);
    chk(!busy && cs_n && !sclk && !launch && !capture, "R3 R6 reset outputs",
        {busy, cs_n, sclk, launch, capture}, 5'b01000);
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h20, rd);
    chk(rd == 32'h00FF_FF03, "R1 reserved bits read zero", rd, 32'h00FF_FF03);
    bus_read(8'h24, rd);
    chk(rd == 0, "R1 other offset reads zero", rd, 0);
    bus_write(8'h20, cfg_word(0, 0, 5, 3));
    wp_en = 1'b1;
    bus_write(8'h20, cfg_word(1, 1, 9, 7));
    bus_read(8'h20, rd);
    chk(rd == cfg_word(0, 0, 5, 3), "R2 protected write ignored", rd, cfg_word(0, 0, 5, 3));
    repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R2 idle level unchanged under protection", sclk, 0);
    wp_en = 1'b0;
    @(negedge clk);
    xfer_start = 1'b1; xfer_bits = '0;
    @(negedge clk);
    xfer_start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(!busy && cs_n, "R9 zero count start ignored", {busy, cs_n}, 1);
      @(negedge clk);
    end

    for (int m = 0; m < 4; m++) run_xfer(m[0], m[1], 4, 0, 3, 0, 0);
    run_xfer(0, 0, 0, 0, 4, 0, 0);
    run_xfer(1, 1, 0, 1, 2, 0, 0);
    run_xfer(0, 1, 255, 255, 2, 0, 0);
    run_xfer(1, 0, 6, 0, 3, 0, 0);
    run_xfer(0, 0, 3, 2, 1, 1, 1);
    for (int k = 0; k < 40; k++) begin
      int dv;
      dv = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 40);
      run_xfer($urandom_range(0, 1), $urandom_range(0, 1), dv,
               ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 60),
               $urandom_range(1, 5), $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule